// File: doc/BRIEF.md
# Audio Processor Serial Command Decoder

This block is the control front end of a stereo audio processor. It is a write-only slave on a two-wire serial bus. It samples the clock line and the data line on the system clock. It recognises bus start and stop conditions and compares the first byte against its own device address. One bit of that address comes from a strap input. Once addressed, it acknowledges every following byte and decodes each one on its own, until the master ends the transfer.

Each byte is one of four commands, chosen by its top bits:

- a channel target command;
- a volume command (fine 1 dB step, coarse 8 dB step, or channel mute);
- a soft-mute or loudness command;
- an input-select command.

Volume commands act only on the channel or channels named by the last target command. The per-channel attenuation is presented as a 7-bit count of dB. That count is the coarse value times eight plus the fine value.

Top module: `audio_ctl_i2c`

## Requirements
- R1: The slave acknowledges, by asserting `sda_pull` during the ninth clock, an address byte equal to {address, 0}. The address is `DEV_ADDR` with bit `STRAP_BIT` replaced by `addr_pin`; with the defaults this gives byte 0x8C for `addr_pin`=1 and 0x88 for `addr_pin`=0. On any other address byte it does not acknowledge, and it ignores all further bytes until the next START.
- R2: START is a falling data line while the clock is high, and STOP is a rising data line while the clock is high. Either one returns the receiver to the address phase or to idle, and `sda_pull` is released by the cycle after STOP.
- R3: After a matched address, every data byte up to STOP is acknowledged and decoded on its own.
- R4: A byte 11xxxxtt sets the channel target. tt=00 selects right only, tt=01 left only, and tt=1x both; `chan_target` shows tt.
- R5: A byte 00xxxfff sets the fine attenuation of each targeted channel to fff dB (0 to 7).
- R6: A byte 01xxcccc with cccc from 0 to 11 sets the coarse attenuation of each targeted channel to 8*cccc dB and clears its mute. With cccc from 12 to 15, it sets the mute of each targeted channel and leaves its attenuation unchanged.
- R7: `att_left` and `att_right` equal 8*coarse + fine, with a range of 0 to 95.
- R8: A byte 101xxxss sets `src_sel` to ss, where 00 = input muted, 01 = input 2, 10 = input 3 and 11 = input 1.
- R9: A byte 100xxkab is a mute or loudness command, decoded on bit k.
  - With k=0 it sets `soft_mute`: ab=00 gives 1 (slow), ab=01 gives 2 (fast), and ab=1x gives 0 (off).
  - With k=1 it sets `loud_mode`: ab=00 gives 0 (off), ab=01 gives 1 (+10 dB), and ab=1x gives 2 (+20 dB).
- R10: After reset the outputs are as follows:
  - both attenuations are 0 and both channels are muted;
  - `chan_target` is 2'b10 (both), the state that follows the byte 8'b11111110;
  - `src_sel`, `loud_mode` and `soft_mute` are 0;
  - `sda_pull` is 0.
- R11: A START or STOP received before the eighth bit of a byte is complete drops that byte, and no register changes.
- R12: An address byte whose last bit is 1 (read) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_pin | input | 1 | Address strap, 1 = open, 0 = grounded |
| sda_pull | output | 1 | Open-drain enable, 1 pulls the data line low |
| att_left | output | 7 | Left attenuation in dB |
| att_right | output | 7 | Right attenuation in dB |
| mute_left | output | 1 | Left channel mute |
| mute_right | output | 1 | Right channel mute |
| chan_target | output | 2 | Current volume target code |
| src_sel | output | 2 | Input select code |
| loud_mode | output | 2 | Loudness: 0 off, 1 +10 dB, 2 +20 dB |
| soft_mute | output | 2 | Soft mute: 0 off, 1 slow, 2 fast |

## Verification
The hardest case to reach from the ports is a byte cut short by a repeated START or by a STOP. The master must stop after only a few clock pulses and then raise the clock with the data line moving. To do this, the bench sends a chosen number of leading bits of a command that would otherwise change the input select. It then issues the condition and checks that the select output is unchanged. The other hard case is an ignored transaction after an address mismatch. There the bench follows the wrong address with a valid command and checks both the missing acknowledge and the unchanged register.

// File: rtl/audio_ctl_i2c.sv
module audio_ctl_i2c #(
  parameter logic [6:0] DEV_ADDR  = 7'b1000110,
  parameter int         STRAP_BIT = 1,
  parameter int         COARSE_N  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       addr_pin,
  output logic       sda_pull,
  output logic [6:0] att_left,
  output logic [6:0] att_right,
  output logic       mute_left,
  output logic       mute_right,
  output logic [1:0] chan_target,
  output logic [1:0] src_sel,
  output logic [1:0] loud_mode,
  output logic [1:0] soft_mute
);

  typedef enum logic [1:0] {IDLE, ADDR, DATA} phase_t;

  localparam logic [3:0] LAST_COARSE = 4'(COARSE_N - 1);

  logic [2:0] scl_sh, sda_sh;
  logic       scl_s, scl_p, sda_s, sda_p;
  logic       start_det, stop_det, scl_rise, scl_fall;
  phase_t     phase;
  logic [3:0] nbits;
  logic [7:0] shreg;
  logic       ack_on;
  logic [6:0] my_addr;
  logic       hit, byte_done, apply, to_l, to_r;
  logic [3:0] crs_l, crs_r;
  logic [2:0] fin_l, fin_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_in};
      sda_sh <= {sda_sh[1:0], sda_in};
    end

  assign scl_s = scl_sh[1];
  assign scl_p = scl_sh[2];
  assign sda_s = sda_sh[1];
  assign sda_p = sda_sh[2];

  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;

  always_comb begin
    my_addr = DEV_ADDR;
    my_addr[STRAP_BIT] = addr_pin;
  end

  assign hit       = (shreg == {my_addr, 1'b0});
  assign byte_done = scl_fall & (nbits == 4'd8) & ~ack_on & (phase != IDLE);
  assign apply     = byte_done & (phase == DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase    <= IDLE;
      nbits    <= '0;
      shreg    <= '0;
      ack_on   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      phase    <= ADDR;
      nbits    <= '0;
      ack_on   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      phase    <= IDLE;
      nbits    <= '0;
      ack_on   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (phase != IDLE) begin
      if (scl_rise && nbits < 4'd8) begin
        shreg <= {shreg[6:0], sda_s};
        nbits <= nbits + 4'd1;
      end else if (scl_fall && nbits == 4'd8) begin
        if (!ack_on) begin
          if (phase == ADDR && !hit) begin
            phase <= IDLE;
            nbits <= '0;
          end else begin
            ack_on   <= 1'b1;
            sda_pull <= 1'b1;
          end
        end else begin
          ack_on   <= 1'b0;
          sda_pull <= 1'b0;
          nbits    <= '0;
          phase    <= DATA;
        end
      end
    end

  assign to_l = (chan_target != 2'b00);
  assign to_r = (chan_target != 2'b01);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chan_target <= 2'b10;
      src_sel     <= 2'b00;
      loud_mode   <= 2'd0;
      soft_mute   <= 2'd0;
      crs_l       <= '0;
      crs_r       <= '0;
      fin_l       <= '0;
      fin_r       <= '0;
      mute_left   <= 1'b1;
      mute_right  <= 1'b1;
    end else if (apply) begin
      casez (shreg)
        8'b11??????: chan_target <= shreg[1:0];
        8'b101?????: src_sel <= shreg[1:0];
        8'b100?????:
          if (shreg[2]) loud_mode <= shreg[1] ? 2'd2 : (shreg[0] ? 2'd1 : 2'd0);
          else          soft_mute <= shreg[1] ? 2'd0 : (shreg[0] ? 2'd2 : 2'd1);
        8'b00??????: begin
          if (to_l) fin_l <= shreg[2:0];
          if (to_r) fin_r <= shreg[2:0];
        end
        default: begin
          if (shreg[3:0] > LAST_COARSE) begin
            if (to_l) mute_left  <= 1'b1;
            if (to_r) mute_right <= 1'b1;
          end else begin
            if (to_l) begin crs_l <= shreg[3:0]; mute_left  <= 1'b0; end
            if (to_r) begin crs_r <= shreg[3:0]; mute_right <= 1'b0; end
          end
        end
      endcase
    end

  assign att_left  = {crs_l, fin_l};
  assign att_right = {crs_r, fin_r};

  // R1
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (phase != IDLE) && !scl_s);

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull && (phase == IDLE));

  // R7
  att_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (att_left <= 7'd95) && (att_right <= 7'd95));

  // R9
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loud_mode != 2'd3) && (soft_mute != 2'd3));

  // R11
  src_only_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != $past(src_sel)) |-> $past(apply));

  // R11
  chan_only_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_target != $past(chan_target)) |-> $past(apply));

endmodule

// File: tb/tb_audio_ctl_i2c.sv
module tb_audio_ctl_i2c;
  logic clk = 0;
  logic rst_n = 0;
  logic scl = 1, m_sda = 1, addr_pin = 1;
  logic sda_pull;
  logic [6:0] att_left, att_right;
  logic mute_left, mute_right;
  logic [1:0] chan_target, src_sel, loud_mode, soft_mute;
  wire  sda_line = m_sda & ~sda_pull;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_ctl_i2c dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .addr_pin(addr_pin),
    .sda_pull(sda_pull), .att_left(att_left), .att_right(att_right),
    .mute_left(mute_left), .mute_right(mute_right), .chan_target(chan_target),
    .src_sel(src_sel), .loud_mode(loud_mode), .soft_mute(soft_mute));

  task automatic q();
    repeat (10) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1; q(); scl = 1; q(); m_sda = 0; q(); scl = 0; q();
  endtask

  task automatic bus_stop();
    m_sda = 0; q(); scl = 1; q(); m_sda = 1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; q(); scl = 1; q(); q(); scl = 0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    m_sda = 1; q(); scl = 1; q();
    acked = !sda_line;
    q(); scl = 0; q();
  endtask

  task automatic put(input logic [7:0] b, input string req);
    bit a;
    send_byte(b, a);
    chk(a, req, a, 1);
  endtask

  task automatic t_reset();
    chk(att_left == 0 && att_right == 0, "R10 att", att_left, 0);
    chk(mute_left && mute_right, "R10 mute", {mute_left, mute_right}, 3);
    chk(chan_target == 2'b10, "R10 chan", chan_target, 2);
    chk(src_sel == 0 && loud_mode == 0 && soft_mute == 0, "R10 modes",
        {src_sel, loud_mode, soft_mute}, 0);
    chk(!sda_pull, "R10 sda", sda_pull, 0);
  endtask

  task automatic t_address();
    bit a;
    bus_start(); send_byte(8'h8D, a); bus_stop();
    chk(!a, "R12 read nack", a, 0);
    addr_pin = 0; q();
    bus_start(); send_byte(8'h8C, a);
    chk(!a, "R1 strap mismatch nack", a, 0);
    send_byte(8'hA3, a); bus_stop();
    chk(src_sel == 0, "R1 ignored after nack", src_sel, 0);
    bus_start(); send_byte(8'h88, a);
    chk(a, "R1 grounded strap ack", a, 1);
    put(8'hA2, "R3 data ack"); bus_stop();
    chk(src_sel == 2, "R1 grounded addr write", src_sel, 2);
    chk(!sda_pull, "R2 released after stop", sda_pull, 0);
    addr_pin = 1; q();
  endtask

  task automatic t_volume();
    bus_start(); put(8'h8C, "R1 ack");
    put(8'hC1, "R3"); put(8'h05, "R3"); put(8'h43, "R3");
    chk(chan_target == 1, "R4 left target", chan_target, 1);
    chk(att_left == 29, "R7 left 24+5", att_left, 29);
    chk(att_right == 0 && mute_right, "R4 right untouched", att_right, 0);
    chk(!mute_left, "R6 coarse unmutes", mute_left, 0);
    put(8'hC0, "R3"); put(8'h4B, "R3"); put(8'h07, "R3");
    chk(att_right == 95 && !mute_right, "R7 right max 95", att_right, 95);
    chk(att_left == 29, "R5 left untouched", att_left, 29);
    put(8'hC2, "R3"); put(8'h4C, "R3");
    chk(mute_left && mute_right, "R6 both mute code 12", {mute_left, mute_right}, 3);
    chk(att_left == 29 && att_right == 95, "R6 mute keeps att", att_left, 29);
    put(8'h40, "R3"); bus_stop();
    chk(att_left == 5 && att_right == 7, "R6 both coarse 0", att_right, 7);
    chk(!mute_left && !mute_right, "R6 both unmuted", {mute_left, mute_right}, 0);
  endtask

  task automatic t_modes();
    bus_start(); put(8'h8C, "R1 ack");
    put(8'h80, "R3"); chk(soft_mute == 1, "R9 slow", soft_mute, 1);
    put(8'h81, "R3"); chk(soft_mute == 2, "R9 fast", soft_mute, 2);
    put(8'h82, "R3"); chk(soft_mute == 0, "R9 off", soft_mute, 0);
    put(8'h85, "R3"); chk(loud_mode == 1, "R9 loud10", loud_mode, 1);
    put(8'h86, "R3"); chk(loud_mode == 2, "R9 loud20", loud_mode, 2);
    put(8'h84, "R3"); chk(loud_mode == 0, "R9 loud off", loud_mode, 0);
    put(8'hA1, "R3"); chk(src_sel == 1, "R8 in2", src_sel, 1);
    put(8'hA3, "R3"); chk(src_sel == 3, "R8 in1", src_sel, 3);
    put(8'hA0, "R3"); chk(src_sel == 0, "R8 muted", src_sel, 0);
    bus_stop();
  endtask

  task automatic t_abort();
    bus_start(); put(8'h8C, "R1 ack");
    send_bits(8'hA2, 4);
    bus_start();
    chk(src_sel == 0, "R11 restart drops byte", src_sel, 0);
    put(8'h8C, "R2 restart address ack");
    send_bits(8'hA1, 7);
    bus_stop();
    chk(src_sel == 0, "R11 stop drops byte", src_sel, 0);
    chk(!sda_pull, "R2 idle after stop", sda_pull, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_address();
    t_volume();
    t_modes();
    t_abort();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule